// File: doc/BRIEF.md
# Addressable Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line for a multi-drop bus. A fractional baud generator turns a 16-bit divisor and a prescale choice into a strobe at sixteen times the bit rate. A recovery stage votes three samples around the middle of each bit and shifts 8 or 9 data bits into a frame. Completed frames go into a small FIFO together with their ninth bit and their framing-error flag.

In 9-bit mode, an address filter can throw away every frame whose ninth bit is clear. A node keeps the filter on until its own address arrives and then turns it off so that it can take the data that follows. When a frame completes while the FIFO is full, the block latches an overrun and stops receiving until software drops the receive enable. The FIFO contents are kept. Software reads the head entry from the read ports and pops it with a one-cycle pulse.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After reset, `rx_ready_o`, `irq_o` and `overrun_o` are 0, and `idle_o` is 1.
- R2: A frame is a low start bit, then data bits LSB first, then a stop bit. In 8-bit mode the byte appears on `rd_data_o`, `rd_bit9_o` reads 0 and `rx_ready_o` goes to 1 once the frame has been received.
- R3: One bit lasts (D+1)*P clock cycles, where D is {`div_hi_i`,`div_lo_i`}. P is 64 when `pre_sel_i`=00, 16 when it is 01, and 4 when it is 10 or 11. In the divide-by-4 setting D must be at least 3.
- R4: When `nine_bit_i`=1, a ninth data bit follows the eight data bits and is reported on `rd_bit9_o` beside its byte.
- R5: When `nine_bit_i`=1 and `addr_det_i`=1, frames whose ninth bit is 0 are discarded and frames whose ninth bit is 1 are stored. When `addr_det_i`=0, or in 8-bit mode, every frame is stored.
- R6: `irq_o` is 1 exactly when `rx_ready_o`=1 and `irq_en_i`=1.
- R7: A frame whose stop bit is sampled low is stored with `rd_ferr_o`=1, and `rd_ferr_o` is reported with that entry.
- R8: The FIFO holds two entries and returns them in arrival order. A `pop_i` pulse removes the head. A pop while the FIFO is empty is ignored.
- R9: If a frame completes while the FIFO holds two entries, `overrun_o` goes to 1 and the frame is lost. Later frames are ignored until `rx_en_i` goes low. Driving `rx_en_i` low clears `overrun_o` and keeps the stored entries.
- R10: The start bit is confirmed by a majority of three samples around its middle. A low pulse shorter than that returns the receiver to idle and stores nothing.
- R11: Reception runs only while both `port_en_i` and `rx_en_i` are 1. Frames sent at other times are not stored.
- R12: `idle_o` is 0 from the detection of a start edge until the stop bit has been sampled, and 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| port_en_i | input | 1 | Serial port enable |
| rx_en_i | input | 1 | Receive enable; a low level clears overrun |
| nine_bit_i | input | 1 | Selects 9 data bits per frame |
| addr_det_i | input | 1 | Address filter enable (9-bit mode only) |
| irq_en_i | input | 1 | Receive interrupt enable |
| div_hi_i | input | 8 | Upper half of the baud divisor |
| div_lo_i | input | 8 | Lower half of the baud divisor |
| pre_sel_i | input | 2 | Prescale: 00 /64, 01 /16, 1x /4 |
| pop_i | input | 1 | Removes the head FIFO entry |
| rd_data_o | output | 8 | Data byte of the head entry |
| rd_bit9_o | output | 1 | Ninth bit of the head entry |
| rd_ferr_o | output | 1 | Framing error of the head entry |
| rx_ready_o | output | 1 | FIFO holds at least one entry |
| irq_o | output | 1 | Receive interrupt |
| overrun_o | output | 1 | Overrun latched; reception halted |
| idle_o | output | 1 | No frame in progress |

## Verification
A recovery state machine stuck outside idle shows as `idle_o` held low, and no further frame reaches `rx_ready_o`. A skewed sample counter or divisor shows as corrupted bytes within a single frame, at every rate setting. Wrong FIFO pointers show up on the next pop, as a repeated or out-of-order byte or as a ready flag that stays high with an empty queue. A broken overrun latch shows within one frame: either a fourth byte is accepted or reception fails to resume after the receive enable is toggled.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
   localparam int unsigned OSR   = 16;
   localparam int unsigned CNT_W = $clog2(OSR);

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/mdrop_rx_baud.sv
module mdrop_rx_baud #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [1:0]       pre_sel_i,
   output logic             strobe_o
);
   // accumulator counts quarter clocks; threshold = (div+1)*prescale/4
   localparam int unsigned ACC_W = DIV_W + 6;

   logic [ACC_W-1:0] base, thresh, acc, acc_sum;
   logic             hit;

   assign base = ACC_W'(div_i) + ACC_W'(1);

   always_comb begin
      unique case (pre_sel_i)
         2'b00:   thresh = base << 4;
         2'b01:   thresh = base << 2;
         default: thresh = base;
      endcase
   end

   assign acc_sum  = acc + ACC_W'(4);
   assign hit      = (acc_sum >= thresh);
   assign strobe_o = run_i & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (!run_i) acc <= '0;
      else if (hit)    acc <= acc_sum - thresh;
      else             acc <= acc_sum;
   end

   a_r3_strobe_needs_run : assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> run_i);
endmodule

// File: rtl/mdrop_rx_shift.sv
module mdrop_rx_shift
   import mdrop_rx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          VOTE3  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              strobe_i,
   input  logic              rx_i,
   input  logic              nine_bit_i,
   output logic              done_o,
   output logic [DATA_W-1:0] frame_o,
   output logic              bit9_o,
   output logic              ferr_o,
   output logic              idle_o
);
   localparam int unsigned BIDX_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] V_LO  = CNT_W'(OSR/2 - 1);
   localparam logic [CNT_W-1:0] V_MID = CNT_W'(OSR/2);
   localparam logic [CNT_W-1:0] V_HI  = CNT_W'(OSR/2 + 1);
   localparam logic [CNT_W-1:0] C_END = CNT_W'(OSR - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIDX_W-1:0] bidx, last_idx;
   logic [DATA_W:0]   shreg;
   logic              vote, done_q, ferr_q;

   assign last_idx = nine_bit_i ? BIDX_W'(DATA_W) : BIDX_W'(DATA_W - 1);

   generate
      if (VOTE3) begin : g_vote3
         logic s_a, s_b;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_a <= 1'b1;
               s_b <= 1'b1;
            end else if (en_i && strobe_i && state != ST_IDLE) begin
               if (cnt == V_LO)  s_a <= rx_i;
               if (cnt == V_MID) s_b <= rx_i;
            end
         end
         assign vote = (s_a & s_b) | (s_a & rx_i) | (s_b & rx_i);
      end else begin : g_vote1
         assign vote = rx_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         shreg  <= '0;
         done_q <= 1'b0;
         ferr_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!en_i) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else if (strobe_i) begin
            unique case (state)
               ST_IDLE: begin
                  if (!rx_i) begin
                     state <= ST_START;
                     cnt   <= '0;
                  end
               end
               ST_START: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == V_HI && vote) begin
                     state <= ST_IDLE;
                  end else if (cnt == C_END) begin
                     state <= ST_DATA;
                     bidx  <= '0;
                  end
               end
               ST_DATA: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == V_HI) shreg <= {vote, shreg[DATA_W:1]};
                  if (cnt == C_END) begin
                     bidx <= bidx + 1'b1;
                     if (bidx == last_idx) state <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == V_HI) begin
                     done_q <= 1'b1;
                     ferr_q <= ~vote;
                     state  <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign done_o  = done_q;
   assign ferr_o  = ferr_q;
   assign frame_o = nine_bit_i ? shreg[DATA_W-1:0] : shreg[DATA_W:1];
   assign bit9_o  = nine_bit_i & shreg[DATA_W];
   assign idle_o  = (state == ST_IDLE);

   a_r12_leave_idle_on_low : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_o) |-> $past(!rx_i));
   a_r10_done_after_stop : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(state == ST_STOP));
endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
   parameter int unsigned WIDTH = 10,
   parameter int unsigned DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic             empty_o,
   output logic             full_o
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mdrop_rx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign empty_o = (count == '0);
   assign full_o  = (count == CNT_W'(DEPTH));
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o;
   assign rdata_o = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         unique case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r8_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   a_r8_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DIV_W      = 16,
   parameter int unsigned FIFO_DEPTH = 2,
   parameter bit          VOTE3      = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_i,
   input  logic                 port_en_i,
   input  logic                 rx_en_i,
   input  logic                 nine_bit_i,
   input  logic                 addr_det_i,
   input  logic                 irq_en_i,
   input  logic [DIV_W/2-1:0]   div_hi_i,
   input  logic [DIV_W/2-1:0]   div_lo_i,
   input  logic [1:0]           pre_sel_i,
   input  logic                 pop_i,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic                 rd_bit9_o,
   output logic                 rd_ferr_o,
   output logic                 rx_ready_o,
   output logic                 irq_o,
   output logic                 overrun_o,
   output logic                 idle_o
);
   localparam int unsigned ENT_W = DATA_W + 2;

   generate
      if ((DIV_W % 2) != 0 || DIV_W < 4) begin : g_bad_div
         $error("mdrop_uart_rx: DIV_W must be even and at least 4");
      end
      if (DATA_W < 5) begin : g_bad_data
         $error("mdrop_uart_rx: DATA_W must be at least 5");
      end
   endgenerate

   logic              rx_meta, rx_sync;
   logic              active, run, strobe;
   logic              frm_done, frm_bit9, frm_ferr, frm_accept;
   logic [DATA_W-1:0] frm_data;
   logic              fifo_empty, fifo_full;
   logic [ENT_W-1:0]  head;
   logic              overrun_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_meta <= 1'b1;
         rx_sync <= 1'b1;
      end else begin
         rx_meta <= rx_i;
         rx_sync <= rx_meta;
      end
   end

   assign active = port_en_i & rx_en_i;
   assign run    = active & ~overrun_q;

   mdrop_rx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .div_i     ({div_hi_i, div_lo_i}),
      .pre_sel_i (pre_sel_i),
      .strobe_o  (strobe)
   );

   mdrop_rx_shift #(.DATA_W(DATA_W), .VOTE3(VOTE3)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (run),
      .strobe_i   (strobe),
      .rx_i       (rx_sync),
      .nine_bit_i (nine_bit_i),
      .done_o     (frm_done),
      .frame_o    (frm_data),
      .bit9_o     (frm_bit9),
      .ferr_o     (frm_ferr),
      .idle_o     (idle_o)
   );

   assign frm_accept = frm_done & (~(nine_bit_i & addr_det_i) | frm_bit9);

   mdrop_rx_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (frm_accept & ~fifo_full),
      .wdata_i ({frm_ferr, frm_bit9, frm_data}),
      .pop_i   (pop_i),
      .rdata_o (head),
      .empty_o (fifo_empty),
      .full_o  (fifo_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         overrun_q <= 1'b0;
      else if (!rx_en_i)                  overrun_q <= 1'b0;
      else if (frm_accept && fifo_full)   overrun_q <= 1'b1;
   end

   assign rd_data_o  = head[DATA_W-1:0];
   assign rd_bit9_o  = head[DATA_W];
   assign rd_ferr_o  = head[DATA_W+1];
   assign rx_ready_o = ~fifo_empty;
   assign irq_o      = ~fifo_empty & irq_en_i;
   assign overrun_o  = overrun_q;

   a_r9_halted_no_frame : assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |-> !frm_done);
   a_r9_set_on_full : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> $past(frm_accept && fifo_full));
   a_r11_off_goes_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !(port_en_i && rx_en_i) |=> idle_o);
endmodule

// File: tb/mdrop_uart_rx_tb.sv
module mdrop_uart_rx_tb;
   localparam int CLK_NS = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       port_en = 1'b0, rx_en = 1'b0, nine_bit = 1'b0, addr_det = 1'b0, irq_en = 1'b0;
   logic [7:0] div_hi = '0, div_lo = '0;
   logic [1:0] pre_sel = 2'b01;
   logic       pop = 1'b0;
   logic [7:0] rd_data;
   logic       rd_bit9, rd_ferr, rx_ready, irq, overrun, idle;

   int checks = 0;
   int errors = 0;
   int bclk   = 16;

   always #(CLK_NS/2) clk = ~clk;

   mdrop_uart_rx u_dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .port_en_i(port_en), .rx_en_i(rx_en),
      .nine_bit_i(nine_bit), .addr_det_i(addr_det), .irq_en_i(irq_en),
      .div_hi_i(div_hi), .div_lo_i(div_lo), .pre_sel_i(pre_sel), .pop_i(pop),
      .rd_data_o(rd_data), .rd_bit9_o(rd_bit9), .rd_ferr_o(rd_ferr),
      .rx_ready_o(rx_ready), .irq_o(irq), .overrun_o(overrun), .idle_o(idle)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] ps, input logic [15:0] dv);
      @(negedge clk);
      pre_sel = ps;
      {div_hi, div_lo} = dv;
      bclk = (int'(dv) + 1) * ((ps == 2'b00) ? 64 : (ps == 2'b01) ? 16 : 4);
   endtask

   task automatic send(input logic [8:0] val, input int nb, input logic stop_v, input bit probe);
      @(negedge clk);
      rx = 1'b0;
      repeat (bclk) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rx = val[i];
         if (probe && i == 2) chk("R12 idle low mid-frame", idle, 0);
         repeat (bclk) @(negedge clk);
      end
      rx = stop_v;
      repeat (bclk) @(negedge clk);
      rx = 1'b1;
      repeat (2 * bclk) @(negedge clk);
   endtask

   task automatic do_pop();
      @(negedge clk) pop = 1'b1;
      @(negedge clk) pop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 ready", rx_ready, 0);
      chk("R1 irq", irq, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 idle", idle, 1);
   endtask

   task automatic t_basic();
      cfg(2'b01, 16'd0);
      send(9'h0A5, 8, 1'b1, 1'b0);
      chk("R2 ready", rx_ready, 1);
      chk("R2 data", rd_data, 8'hA5);
      chk("R2 bit9", rd_bit9, 0);
      chk("R6 irq off", irq, 0);
      @(negedge clk) irq_en = 1'b1;
      @(negedge clk);
      chk("R6 irq on", irq, 1);
      do_pop();
      chk("R2 empty after pop", rx_ready, 0);
      chk("R6 irq clears", irq, 0);
      irq_en = 1'b0;
   endtask

   task automatic t_rates();
      cfg(2'b00, 16'd0);
      send(9'h03C, 8, 1'b1, 1'b0);
      chk("R3 /64 data", rd_data, 8'h3C);
      do_pop();
      cfg(2'b10, 16'd3);
      send(9'h0C3, 8, 1'b1, 1'b0);
      chk("R3 /4 data", rd_data, 8'hC3);
      do_pop();
      cfg(2'b01, 16'd1);
      send(9'h05A, 8, 1'b1, 1'b0);
      chk("R3 /16 div1 data", rd_data, 8'h5A);
      do_pop();
      cfg(2'b11, 16'h0100);
      send(9'h0E7, 8, 1'b1, 1'b0);
      chk("R3 high divisor data", rd_data, 8'hE7);
      do_pop();
      cfg(2'b01, 16'd0);
   endtask

   task automatic t_nine();
      nine_bit = 1'b1;
      send(9'h15B, 9, 1'b1, 1'b0);
      chk("R4 data", rd_data, 8'h5B);
      chk("R4 bit9 set", rd_bit9, 1);
      do_pop();
      send(9'h081, 9, 1'b1, 1'b0);
      chk("R4 bit9 clear", {rd_bit9, rd_data}, 9'h081);
      do_pop();
   endtask

   task automatic t_addr();
      addr_det = 1'b1;
      send(9'h011, 9, 1'b1, 1'b0);
      chk("R5 data frame dropped", rx_ready, 0);
      send(9'h142, 9, 1'b1, 1'b0);
      chk("R5 address stored", rx_ready, 1);
      chk("R5 address value", {rd_bit9, rd_data}, 9'h142);
      do_pop();
      addr_det = 1'b0;
      send(9'h033, 9, 1'b1, 1'b0);
      chk("R5 filter off accepts", {rx_ready, rd_bit9, rd_data}, 10'h233);
      do_pop();
      nine_bit = 1'b0;
      addr_det = 1'b1;
      send(9'h077, 8, 1'b1, 1'b0);
      chk("R5 8-bit ignores filter", {rx_ready, rd_data}, 9'h177);
      do_pop();
      addr_det = 1'b0;
   endtask

   task automatic t_ferr();
      send(9'h096, 8, 1'b0, 1'b0);
      chk("R7 ferr", rd_ferr, 1);
      chk("R7 data", rd_data, 8'h96);
      do_pop();
      chk("R7 no spurious frame", rx_ready, 0);
      send(9'h069, 8, 1'b1, 1'b0);
      chk("R7 ferr clear", {rd_ferr, rd_data}, 9'h069);
      do_pop();
   endtask

   task automatic t_fifo();
      send(9'h011, 8, 1'b1, 1'b0);
      send(9'h022, 8, 1'b1, 1'b0);
      chk("R8 head first", rd_data, 8'h11);
      do_pop();
      chk("R8 second", {rx_ready, rd_data}, 9'h122);
      do_pop();
      chk("R8 empty", rx_ready, 0);
      do_pop();
      chk("R8 pop on empty ignored", rx_ready, 0);
      send(9'h044, 8, 1'b1, 1'b0);
      chk("R8 after empty pop", {rx_ready, rd_data}, 9'h144);
      do_pop();
   endtask

   task automatic t_overrun();
      send(9'h001, 8, 1'b1, 1'b0);
      send(9'h002, 8, 1'b1, 1'b0);
      chk("R9 no overrun at two", overrun, 0);
      send(9'h003, 8, 1'b1, 1'b0);
      chk("R9 overrun set", overrun, 1);
      chk("R9 head kept", rd_data, 8'h01);
      do_pop();
      chk("R9 second kept", rd_data, 8'h02);
      do_pop();
      chk("R9 third lost", rx_ready, 0);
      send(9'h004, 8, 1'b1, 1'b0);
      chk("R9 halted", rx_ready, 0);
      chk("R9 still latched", overrun, 1);
      @(negedge clk) rx_en = 1'b0;
      @(negedge clk) rx_en = 1'b1;
      chk("R9 cleared by toggle", overrun, 0);
      send(9'h005, 8, 1'b1, 1'b0);
      chk("R9 resumes", {rx_ready, rd_data}, 9'h105);
      do_pop();
   endtask

   task automatic t_glitch();
      @(negedge clk) rx = 1'b0;
      repeat (3) @(negedge clk);
      rx = 1'b1;
      repeat (3 * bclk) @(negedge clk);
      chk("R10 glitch back to idle", idle, 1);
      chk("R10 glitch not stored", rx_ready, 0);
      send(9'h0B4, 8, 1'b1, 1'b0);
      chk("R10 frame after glitch", {rx_ready, rd_data}, 9'h1B4);
      do_pop();
   endtask

   task automatic t_enable();
      @(negedge clk) port_en = 1'b0;
      send(9'h066, 8, 1'b1, 1'b0);
      chk("R11 port off", rx_ready, 0);
      chk("R11 idle when off", idle, 1);
      @(negedge clk) begin port_en = 1'b1; rx_en = 1'b0; end
      send(9'h066, 8, 1'b1, 1'b0);
      chk("R11 rx off", rx_ready, 0);
      @(negedge clk) rx_en = 1'b1;
      send(9'h067, 8, 1'b1, 1'b1);
      chk("R11 on again", {rx_ready, rd_data}, 9'h167);
      chk("R12 idle after frame", idle, 1);
      do_pop();
   endtask

   initial begin
      #(CLK_NS * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      port_en = 1'b1;
      rx_en = 1'b1;
      t_basic();
      t_rates();
      t_nine();
      t_addr();
      t_ferr();
      t_fifo();
      t_overrun();
      t_glitch();
      t_enable();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule